// File: doc/BRIEF.md
# AC-link Frame Master (serializer, deserializer and codec reset sequencer)

This block is the bit-level master of an AC'97-style serial link to an audio codec. It runs entirely on the bit clock that the codec supplies. It generates the frame sync, shifts one 256-bit frame after another out on the serial data output, and shifts the codec's frames in on the serial data input. Each frame consists of one 16-bit tag word followed by twelve 20-bit slot words, and every word is sent most significant bit first.

On the parallel side the block takes a tag and twelve slot words for each outgoing frame. It captures them once per frame, at the frame boundary. For each incoming frame it presents the received tag and slots together with a one-cycle strobe. A small sequencer brings the codec up. It first holds the codec in cold reset while the link lines stay low, so the codec cannot latch a test mode. It then gives a warm-reset pulse on the sync line, with quiet gaps on either side, before framing begins. The whole sequence can be restarted later with a cold request, and the warm pulse can be repeated on its own with a warm request.

Top module: `aclink_master`

## Requirements
- R1: While `rst_n` is low, `codec_rst_n`, `link_sync`, `link_sdo` and `rx_valid` are all low.
- R2: After `rst_n` is released, or on the rising edge after `reinit_req` is seen (in any state), `codec_rst_n` is low for exactly COLD_CYC bit clocks. During that time `link_sync` and `link_sdo` are low.
- R3: Once cold reset ends, `link_sync` is low for GAP_CYC bit clocks, then high for WARM_CYC bit clocks, then low for GAP_CYC bit clocks. `codec_rst_n` stays high and `link_sdo` stays low throughout.
- R4: Right after the second gap, framing starts with one lead bit clock in which `link_sync` is high and `link_sdo` is low. Frames of 256 bit clocks then follow back to back with no idle bits.
- R5: In every frame `link_sync` is high for exactly 16 bit clocks: the bit clock just before frame bit 0, and frame bits 0 to 14. Outputs change only on rising bit-clock edges.
- R6: Frame bit 0 is `tx_tag[15]`, and the tag goes out MSB first. Slots 1 to 12 follow in order, each MSB first. Slot k is held in `tx_slots[20k-1:20k-20]`.
- R7: `tx_tag` and `tx_slots` are captured on the rising edge that starts frame bit 0. Changing them later in the frame has no effect on that frame's serial data.
- R8: `link_sdi` is sampled on the falling bit-clock edge. `rx_tag` holds received frame bits 0 to 15, MSB first. `rx_slots` uses the same slot mapping as R6.
- R9: `rx_valid` is a one-cycle pulse, high during bit 0 of the frame that follows a complete received frame, with `rx_tag` and `rx_slots` updated in that same cycle. There is no pulse for the lead bit or for a partly received frame.
- R10: A `warm_req` seen while framing stops framing at the next rising edge. `codec_rst_n` stays high. The gap, warm-pulse and gap sequence of R3 then runs, followed by the lead bit and framing of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| reinit_req | input | 1 | Restart the full cold-reset sequence |
| warm_req | input | 1 | While framing, stop and redo the warm-reset pulse |
| tx_tag | input | 16 | Tag word for the next outgoing frame |
| tx_slots | input | 240 | Twelve 20-bit outgoing slots; slot k at bits 20k-1:20k-20 |
| rx_tag | output | 16 | Tag word of the last complete received frame |
| rx_slots | output | 240 | Twelve received slots, same mapping as tx_slots |
| rx_valid | output | 1 | One-cycle strobe: a new received frame is presented |
| link_sync | output | 1 | Frame sync, also used for the warm-reset pulse |
| link_sdo | output | 1 | Serial data to the codec |
| link_sdi | input | 1 | Serial data from the codec |
| codec_rst_n | output | 1 | Active-low cold reset to the codec |

## Verification
The bench measures each reset phase in bit clocks, so a timer that is off by one shows up as a wrong phase length. It also checks the lead bit, because a design that raised sync on bit 0 instead of one bit early would put the whole frame one position late. Incoming data is switched to its inverse right after each falling edge, so a receiver that sampled on the rising edge would return inverted words. In one frame the transmit words are changed midway, and a design that did not capture them at the boundary would send a mixed frame. A strobe produced for the lead bit, or after a warm restart, is caught as an extra `rx_valid`.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

  localparam int TAG_W    = 16;
  localparam int SLOT_W   = 20;
  localparam int N_SLOT   = 12;
  localparam int SLOTS_W  = N_SLOT * SLOT_W;
  localparam int FRAME_W  = TAG_W + SLOTS_W;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int LAST_IDX = FRAME_W - 1;

  typedef logic [IDX_W-1:0] bit_idx_t;

  typedef enum logic [2:0] {
    SEQ_COLD,
    SEQ_GAP_A,
    SEQ_WARM,
    SEQ_GAP_B,
    SEQ_RUN
  } seq_state_e;

  // Sync is high on the lead bit (last index) and on tag bits 0..TAG_W-2.
  function automatic logic sync_window(bit_idx_t idx);
    return (idx == bit_idx_t'(LAST_IDX)) || (idx < bit_idx_t'(TAG_W - 1));
  endfunction

  function automatic bit_idx_t next_idx(bit_idx_t idx);
    return (idx == bit_idx_t'(LAST_IDX)) ? '0 : idx + 1'b1;
  endfunction

  // Serial order: tag MSB first, then slot 1 .. slot N, each MSB first.
  function automatic logic [FRAME_W-1:0] pack_frame(logic [TAG_W-1:0] tag,
                                                     logic [SLOTS_W-1:0] slots);
    logic [FRAME_W-1:0] f;
    f[FRAME_W-1 -: TAG_W] = tag;
    for (int k = 0; k < N_SLOT; k++) begin
      f[SLOTS_W-1-k*SLOT_W -: SLOT_W] = slots[k*SLOT_W +: SLOT_W];
    end
    return f;
  endfunction

  function automatic logic [TAG_W-1:0] unpack_tag(logic [FRAME_W-1:0] f);
    return f[FRAME_W-1 -: TAG_W];
  endfunction

  function automatic logic [SLOTS_W-1:0] unpack_slots(logic [FRAME_W-1:0] f);
    logic [SLOTS_W-1:0] s;
    for (int k = 0; k < N_SLOT; k++) begin
      s[k*SLOT_W +: SLOT_W] = f[SLOTS_W-1-k*SLOT_W -: SLOT_W];
    end
    return s;
  endfunction

endpackage

// File: rtl/aclink_rst_seq.sv
module aclink_rst_seq
  import aclink_pkg::*;
#(
  parameter int COLD_CYC = 8,
  parameter int GAP_CYC  = 4,
  parameter int WARM_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reinit_req,
  input  logic       warm_req,
  output logic       codec_rst_n,
  output logic       warm_sync,
  output logic       link_go,
  output logic       link_stop,
  output seq_state_e state
);

  localparam int MAX_A = (COLD_CYC > GAP_CYC) ? COLD_CYC : GAP_CYC;
  localparam int MAX_C = (MAX_A > WARM_CYC) ? MAX_A : WARM_CYC;
  localparam int TW    = $clog2(MAX_C + 1);

  logic [TW-1:0] tmr;

  function automatic logic [TW-1:0] load_of(seq_state_e s);
    case (s)
      SEQ_COLD:            return TW'(COLD_CYC - 1);
      SEQ_GAP_A, SEQ_GAP_B: return TW'(GAP_CYC - 1);
      SEQ_WARM:            return TW'(WARM_CYC - 1);
      default:             return '0;
    endcase
  endfunction

  function automatic seq_state_e succ_of(seq_state_e s);
    case (s)
      SEQ_COLD:  return SEQ_GAP_A;
      SEQ_GAP_A: return SEQ_WARM;
      SEQ_WARM:  return SEQ_GAP_B;
      default:   return SEQ_RUN;
    endcase
  endfunction

  always_comb begin
    codec_rst_n = (state != SEQ_COLD);
    warm_sync   = (state == SEQ_WARM);
    link_go     = (state == SEQ_GAP_B) && (tmr == '0) && !reinit_req;
    link_stop   = (state == SEQ_RUN) && (reinit_req || warm_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_COLD;
      tmr   <= load_of(SEQ_COLD);
    end else if (reinit_req) begin
      state <= SEQ_COLD;
      tmr   <= load_of(SEQ_COLD);
    end else if (state == SEQ_RUN) begin
      if (warm_req) begin
        state <= SEQ_GAP_A;
        tmr   <= load_of(SEQ_GAP_A);
      end
    end else if (tmr == '0) begin
      state <= succ_of(state);
      tmr   <= load_of(succ_of(state));
    end else begin
      tmr <= tmr - 1'b1;
    end
  end

endmodule

// File: rtl/aclink_tx_ser.sv
module aclink_tx_ser
  import aclink_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               stop,
  input  logic [TAG_W-1:0]   tx_tag,
  input  logic [SLOTS_W-1:0] tx_slots,
  output logic               on,
  output bit_idx_t           idx,
  output logic               sync_q,
  output logic               sdo_q
);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame_w;
  bit_idx_t           nidx;
  logic               wrap;

  always_comb begin
    nidx    = next_idx(idx);
    wrap    = (nidx == '0);
    frame_w = pack_frame(tx_tag, tx_slots);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on     <= 1'b0;
      idx    <= '0;
      sync_q <= 1'b0;
      sdo_q  <= 1'b0;
      shreg  <= '0;
    end else if (stop) begin
      on     <= 1'b0;
      idx    <= '0;
      sync_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (go) begin
      on     <= 1'b1;
      idx    <= bit_idx_t'(LAST_IDX);
      sync_q <= 1'b1;
      sdo_q  <= 1'b0;
    end else if (on) begin
      idx    <= nidx;
      sync_q <= sync_window(nidx);
      if (wrap) begin
        sdo_q <= frame_w[FRAME_W-1];
        shreg <= {frame_w[FRAME_W-2:0], 1'b0};
      end else begin
        sdo_q <= shreg[FRAME_W-1];
        shreg <= {shreg[FRAME_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/aclink_rx_des.sv
module aclink_rx_des
  import aclink_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi,
  input  logic               on,
  input  bit_idx_t           idx,
  output logic [TAG_W-1:0]   rx_tag,
  output logic [SLOTS_W-1:0] rx_slots,
  output logic               rx_valid
);

  logic               sdi_s;
  logic               have_start;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] shreg_n;
  logic               frame_end;

  // Input is taken on the falling edge, half a bit after the codec drives it.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdi_s <= 1'b0;
    else        sdi_s <= sdi;
  end

  always_comb begin
    shreg_n   = {shreg[FRAME_W-2:0], sdi_s};
    frame_end = on && have_start && (idx == bit_idx_t'(LAST_IDX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_start <= 1'b0;
      shreg      <= '0;
      rx_tag     <= '0;
      rx_slots   <= '0;
      rx_valid   <= 1'b0;
    end else if (!on) begin
      have_start <= 1'b0;
      rx_valid   <= 1'b0;
    end else begin
      shreg    <= shreg_n;
      rx_valid <= frame_end;
      if (idx == '0) have_start <= 1'b1;
      if (frame_end) begin
        rx_tag   <= unpack_tag(shreg_n);
        rx_slots <= unpack_slots(shreg_n);
      end
    end
  end

endmodule

// File: rtl/aclink_master.sv
module aclink_master
  import aclink_pkg::*;
#(
  parameter int COLD_CYC = 8,
  parameter int GAP_CYC  = 4,
  parameter int WARM_CYC = 6
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                reinit_req,
  input  logic                warm_req,
  input  logic [15:0]         tx_tag,
  input  logic [239:0]        tx_slots,
  output logic [15:0]         rx_tag,
  output logic [239:0]        rx_slots,
  output logic                rx_valid,
  output logic                link_sync,
  output logic                link_sdo,
  input  logic                link_sdi,
  output logic                codec_rst_n
);

  seq_state_e seq_st;
  logic       warm_sync;
  logic       link_go;
  logic       link_stop;
  logic       tx_on;
  bit_idx_t   bit_idx;
  logic       tx_sync;
  logic       tx_sdo;

  aclink_rst_seq #(
    .COLD_CYC(COLD_CYC),
    .GAP_CYC (GAP_CYC),
    .WARM_CYC(WARM_CYC)
  ) seq_i (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .reinit_req (reinit_req),
    .warm_req   (warm_req),
    .codec_rst_n(codec_rst_n),
    .warm_sync  (warm_sync),
    .link_go    (link_go),
    .link_stop  (link_stop),
    .state      (seq_st)
  );

  aclink_tx_ser tx_i (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .go      (link_go),
    .stop    (link_stop),
    .tx_tag  (tx_tag),
    .tx_slots(tx_slots),
    .on      (tx_on),
    .idx     (bit_idx),
    .sync_q  (tx_sync),
    .sdo_q   (tx_sdo)
  );

  aclink_rx_des rx_i (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .sdi     (link_sdi),
    .on      (tx_on),
    .idx     (bit_idx),
    .rx_tag  (rx_tag),
    .rx_slots(rx_slots),
    .rx_valid(rx_valid)
  );

  always_comb begin
    link_sync = tx_on ? tx_sync : warm_sync;
    link_sdo  = tx_on & tx_sdo;
  end

endmodule

// File: rtl/aclink_master_chk.sv
module aclink_master_chk
  import aclink_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     codec_rst_n,
  input logic     sync,
  input logic     sdo,
  input logic     tx_on,
  input bit_idx_t bit_idx,
  input logic     rx_valid
);

  a_r2_quiet_in_cold: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |-> (!sync && !sdo));

  a_r10_warm_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync) && !tx_on) |-> codec_rst_n);

  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && $past(tx_on)) |-> (bit_idx == next_idx($past(bit_idx))));

  a_r5_sync_rises_early: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && $rose(sync)) |-> (bit_idx == bit_idx_t'(LAST_IDX)));

  a_r5_sync_falls_at_tag_end: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && $past(tx_on) && $fell(sync)) |-> (bit_idx == bit_idx_t'(TAG_W - 1)));

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_valid_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bit_idx == '0));

endmodule

bind aclink_master aclink_master_chk chk_i (
  .clk        (bit_clk),
  .rst_n      (rst_n),
  .codec_rst_n(codec_rst_n),
  .sync       (link_sync),
  .sdo        (link_sdo),
  .tx_on      (tx_on),
  .bit_idx    (bit_idx),
  .rx_valid   (rx_valid)
);

// File: tb/aclink_master_tb.sv
module aclink_master_tb_top;

  localparam int COLD = 8;
  localparam int GAP  = 4;
  localparam int WARM = 6;

  // vector: [72:57] tx tag, [56:37] tx seed, [36:21] rx tag, [20:1] rx seed, [0] mid-frame change
  localparam logic [72:0] VEC [4] = '{
    {16'h0000, 20'h00000, 16'h0000, 20'h00000, 1'b0},
    {16'hFFFF, 20'hFFFFF, 16'hFFFF, 20'hFFFFF, 1'b0},
    {16'h9C3A, 20'h1B2C3, 16'h6E15, 20'h5D4E7, 1'b1},
    {16'h8001, 20'h80001, 16'h0001, 20'h00010, 1'b0}
  };

  logic         bit_clk = 1'b0;
  logic         rst_n;
  logic         reinit_req;
  logic         warm_req;
  logic [15:0]  tx_tag;
  logic [239:0] tx_slots;
  logic [15:0]  rx_tag;
  logic [239:0] rx_slots;
  logic         rx_valid;
  logic         link_sync;
  logic         link_sdo;
  logic         link_sdi;
  logic         codec_rst_n;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  fin   = 1'b0;

  always #4 bit_clk = ~bit_clk;

  aclink_master #(.COLD_CYC(COLD), .GAP_CYC(GAP), .WARM_CYC(WARM)) dut_i (
    .bit_clk(bit_clk), .rst_n(rst_n), .reinit_req(reinit_req), .warm_req(warm_req),
    .tx_tag(tx_tag), .tx_slots(tx_slots), .rx_tag(rx_tag), .rx_slots(rx_slots),
    .rx_valid(rx_valid), .link_sync(link_sync), .link_sdo(link_sdo),
    .link_sdi(link_sdi), .codec_rst_n(codec_rst_n)
  );

  task automatic chk(input bit ok, input string rq, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [239:0] mk_slots(logic [19:0] seed);
    logic [239:0] r;
    for (int k = 0; k < 12; k++) begin
      if (seed == 20'h0 || seed == 20'hFFFFF) r[k*20 +: 20] = seed;
      else r[k*20 +: 20] = seed ^ (20'(k + 1) * 20'h0F0F1);
    end
    return r;
  endfunction

  // Expected frame, vector bit 255 = serial bit 0.
  function automatic logic [255:0] mk_frame(logic [15:0] tag, logic [239:0] sl);
    logic [255:0] f;
    for (int b = 0; b < 256; b++) begin
      if (b < 16) f[255-b] = tag[15-b];
      else f[255-b] = sl[((b-16)/20)*20 + (19 - (b-16)%20)];
    end
    return f;
  endfunction

  task automatic step();
    @(negedge bit_clk);
    #1;
  endtask

  // Entered at negedge+1 of the first period to measure.
  task automatic check_seq(input bit cold);
    int n;
    int q;
    n = 0; q = 0;
    while (!codec_rst_n && n < 4096) begin
      if (link_sync || link_sdo) q++;
      n++;
      step();
    end
    if (cold) chk(n == COLD, "R2 cold reset length", 256'(n), 256'(COLD));
    else      chk(n == 0, "R10 codec reset stays high", 256'(n), 256'(0));
    chk(q == 0, "R2 lines low during cold reset", 256'(q), 256'(0));
    n = 0; q = 0;
    while (!link_sync && n < 4096) begin
      if (link_sdo || !codec_rst_n) q++;
      n++;
      step();
    end
    chk(n == GAP, "R3 gap before warm pulse", 256'(n), 256'(GAP));
    n = 0;
    while (link_sync && n < 4096) begin
      if (link_sdo || !codec_rst_n) q++;
      n++;
      step();
    end
    chk(n == WARM, "R3 warm pulse width", 256'(n), 256'(WARM));
    n = 0;
    while (!link_sync && n < 4096) begin
      if (link_sdo || !codec_rst_n) q++;
      n++;
      step();
    end
    chk(n == GAP, "R3 gap after warm pulse", 256'(n), 256'(GAP));
    chk(q == 0, "R3 data low and reset high in sequence", 256'(q), 256'(0));
    chk(!link_sdo && !rx_valid, "R4 lead bit quiet", 256'({link_sdo, rx_valid}), 256'(0));
  endtask

  // Entered at negedge+1 of the lead bit (index 255); returns at the next one.
  task automatic do_frame(input logic [15:0] ttag, input logic [239:0] tsl,
                          input logic [255:0] rxf, input bit mid,
                          input bit chk_prev, input logic [15:0] ptag,
                          input logic [239:0] psl);
    logic [255:0] cap;
    logic [255:0] exp;
    int sync_bad;
    int val_bad;
    tx_tag   = ttag;
    tx_slots = tsl;
    exp      = mk_frame(ttag, tsl);
    sync_bad = 0;
    val_bad  = 0;
    cap      = '0;
    for (int i = 0; i < 256; i++) begin
      @(posedge bit_clk);
      #2;
      link_sdi = rxf[255-i];
      if (mid && i == 100) begin
        tx_tag   = ~ttag;
        tx_slots = ~tsl;
      end
      @(negedge bit_clk);
      #1;
      cap[255-i] = link_sdo;
      if (link_sync != ((i == 255) || (i < 15))) sync_bad++;
      if (i == 0 && chk_prev) begin
        chk(rx_valid == 1'b1, "R9 strobe at bit 0", 256'(rx_valid), 256'(1));
        chk(rx_tag == ptag, "R8 received tag", 256'(rx_tag), 256'(ptag));
        chk(rx_slots == psl, "R8 received slots", 256'(rx_slots), 256'(psl));
      end else if (rx_valid) begin
        val_bad++;
      end
      link_sdi = ~rxf[255-i];
    end
    if (mid) chk(cap == exp, "R7 inputs captured at frame start", cap, exp);
    else     chk(cap == exp, "R6 serial frame order", cap, exp);
    chk(sync_bad == 0, "R5 sync window and R4 frame length", 256'(sync_bad), 256'(0));
    chk(val_bad == 0, "R9 no extra strobe", 256'(val_bad), 256'(0));
  endtask

  task automatic final_rx(input logic [15:0] ptag, input logic [239:0] psl);
    @(negedge bit_clk);
    #1;
    chk(rx_valid == 1'b1, "R9 strobe after last frame", 256'(rx_valid), 256'(1));
    chk(rx_tag == ptag && rx_slots == psl, "R8 last received frame",
        {rx_tag, rx_slots}, {ptag, psl});
  endtask

  initial begin
    logic [15:0]  ptag;
    logic [239:0] psl;
    bit           have;
    rst_n = 1'b0; reinit_req = 1'b0; warm_req = 1'b0;
    tx_tag = '0; tx_slots = '0; link_sdi = 1'b0;
    ptag = '0; psl = '0; have = 1'b0;
    repeat (3) @(negedge bit_clk);
    #1;
    chk(!codec_rst_n && !link_sync && !link_sdo && !rx_valid, "R1 reset state",
        256'({codec_rst_n, link_sync, link_sdo, rx_valid}), 256'(0));
    @(negedge bit_clk);
    rst_n = 1'b1;
    #1;
    check_seq(1'b1);

    // table walk
    for (int v = 0; v < 4; v++) begin
      logic [15:0]  rt;
      logic [239:0] rs;
      rt = VEC[v][36:21];
      rs = mk_slots(VEC[v][20:1]);
      do_frame(VEC[v][72:57], mk_slots(VEC[v][56:37]), mk_frame(rt, rs),
               VEC[v][0], have, ptag, psl);
      ptag = rt; psl = rs; have = 1'b1;
    end
    final_rx(ptag, psl);

    // warm restart while framing (R10)
    warm_req = 1'b1;
    step();
    warm_req = 1'b0;
    check_seq(1'b0);
    do_frame(16'h3C5A, mk_slots(20'h2468A), mk_frame(16'hA55A, mk_slots(20'h13579)),
             1'b0, 1'b0, '0, '0);
    do_frame(16'h0F0F, mk_slots(20'hFEDCB), mk_frame(16'h1234, mk_slots(20'h0ACE1)),
             1'b0, 1'b1, 16'hA55A, mk_slots(20'h13579));

    // full cold restart (R2)
    reinit_req = 1'b1;
    step();
    reinit_req = 1'b0;
    check_seq(1'b1);
    do_frame(16'h7E81, mk_slots(20'h55AA5), mk_frame(16'hC001, mk_slots(20'h3F00F)),
             1'b0, 1'b0, '0, '0);
    final_rx(16'hC001, mk_slots(20'h3F00F));

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bit_clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule